// File: doc/BRIEF.md
# SDRAM Bank Timing Tracker

This block sits beside the command scheduler of a synchronous DRAM controller. It holds the state of four independent banks (closed, or open on a given row). Each cycle it judges whether a candidate command is allowed against the minimum clock spacings of the device. The scheduler presents one candidate each cycle: an operation, a bank, a row and an auto-precharge bit. It reads back a legality flag for every operation type on that bank, the flag for the chosen operation, and whether the row would hit or miss the open row. When `cmd_valid` is high and the candidate is legal, the command counts as issued at that clock edge and the tracker updates its state. An illegal candidate changes nothing and may be presented again.

Each bank keeps down-counters for activate-to-column, activate-to-precharge, write recovery and precharge/auto-precharge completion, plus an age counter that flags a row left open too long. A single shared counter spaces activates across banks. All spacings are parameters given in clocks. The defaults suit a 7 ns clock with burst length 4. The CAS latency input (2 or 3) only affects when a bank closed by read auto-precharge may be activated again.

Top module: `sbt_tracker`

## Requirements
- R1: After reset every bank is closed, no close-due flag is set, and of `legal_vec` only bit 0 (activate) is high.
- R2: Operation codes are 0 activate, 1 read, 2 write, 3 precharge, and `legal_vec[i]` is the flag for code i. An activate is legal only on a closed bank whose precharge time has elapsed, and only when at least T_RRD (2) clocks have passed since the last activate to any bank.
- R3: A read or write is legal only on an open bank, no sooner than T_RCD (3) clocks after its activate.
- R4: A precharge is legal only on an open bank, no sooner than T_RAS (6) clocks after its activate and no sooner than BURST-1+T_WR (4) clocks after its last write command.
- R5: After a precharge, the bank may be activated no sooner than T_RP (3) clocks later.
- R6: A write with `cmd_ap`=1 closes the bank at once. The next activate is legal at max(write + BURST-1+T_WR, activate + T_RAS) + T_RP.
- R7: A read with `cmd_ap`=1 closes the bank at once. The next activate is legal at the later of read + CAS latency + BURST and max(read, activate + T_RAS, write-recovery end) + T_RP.
- R8: A candidate presented while illegal, or with `cmd_valid` low, changes no bank state.
- R9: `row_hit` is high when the addressed bank is open on `cmd_row`, and `row_miss` when it is open on another row. Both are low on a closed bank. `open_rows` holds row of bank b at bits b*ROW_W.
- R10: `close_due[b]` rises T_RAS_MAX clocks after the activate of bank b while the bank stays open.
- R11: The banks are independent: any number of them may be open at once, and `bank_open` shows each one.
- R12: `cmd_legal` equals `legal_vec[cmd_op]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_lat | input | 2 | CAS latency in clocks (2 or 3) |
| cmd_valid | input | 1 | Candidate is to be issued if legal |
| cmd_op | input | 2 | Operation code (0 act, 1 read, 2 write, 3 precharge) |
| cmd_bank | input | BANK_W | Target bank |
| cmd_row | input | ROW_W | Row for activate and hit test |
| cmd_ap | input | 1 | Auto-precharge on read or write |
| legal_vec | output | 4 | Legality per operation code for cmd_bank |
| cmd_legal | output | 1 | Legality of the chosen operation |
| row_hit | output | 1 | Addressed bank open on cmd_row |
| row_miss | output | 1 | Addressed bank open on another row |
| bank_open | output | BANKS | Open flag per bank |
| open_rows | output | BANKS*ROW_W | Open row per bank |
| close_due | output | BANKS | Row open for T_RAS_MAX clocks or more |

## Verification
On every cycle the assertions check the state rules that span cycles: an activate is never legal on an open bank or in the cycle after another activate, a column command is never legal on a closed bank, and an issued activate or precharge opens or closes its bank on the next cycle. They also check that a refused candidate leaves all bank state unchanged. The exact spacing values cannot be seen by a property. These are the boundary cycles of T_RCD, T_RAS, write recovery, T_RP and both auto-precharge formulas under each CAS latency, and the close-due timing. The bench's directed scenarios show them by measuring the first legal cycle. A timestamp model then follows them through random mixes of commands across banks.

// File: rtl/sbt_pkg.sv
`timescale 1ns/1ps
package sbt_pkg;
  typedef enum logic [1:0] {
    OP_ACT = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2,
    OP_PRE = 2'd3
  } sbt_op_e;
endpackage

// File: rtl/sbt_down_cnt.sv
`timescale 1ns/1ps
module sbt_down_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    if (load)            cnt_d = load_val;
    else if (cnt != '0)  cnt_d = cnt - W'(1);
    else                 cnt_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/sbt_bank.sv
`timescale 1ns/1ps
module sbt_bank
  import sbt_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int CW        = 5,
  parameter int AGE_W     = 15,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_WR      = 1,
  parameter int BURST     = 4,
  parameter int T_RAS_MAX = 17142
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  sbt_op_e          op,
  input  logic             ap,
  input  logic [ROW_W-1:0] row,
  input  logic [1:0]       cas_lat,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             act_ok,
  output logic             col_ok,
  output logic             pre_ok,
  output logic             close_due
);
  localparam logic [CW-1:0]    RCD_LD  = CW'(T_RCD - 1);
  localparam logic [CW-1:0]    RAS_LD  = CW'(T_RAS - 1);
  localparam logic [CW-1:0]    RP_LD   = CW'(T_RP - 1);
  localparam logic [CW-1:0]    WR_LD   = CW'(BURST + T_WR - 2);
  localparam logic [CW-1:0]    WAP_LD  = CW'(BURST + T_WR + T_RP - 2);
  localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(T_RAS_MAX);

  logic [CW-1:0] rcd_cnt, ras_cnt, wr_cnt, rp_cnt;
  logic [CW-1:0] ap_base, ap_from_ras, ap_from_wr, ap_ld, rp_ld;
  logic          ld_act, ld_col, ld_wr, ld_ap, ld_pre;
  logic          open_d;
  logic [ROW_W-1:0] row_d;
  logic [AGE_W-1:0] age_q, age_d;

  assign ld_act = issue && (op == OP_ACT);
  assign ld_col = issue && ((op == OP_RD) || (op == OP_WR));
  assign ld_wr  = issue && (op == OP_WR);
  assign ld_ap  = ld_col && ap;
  assign ld_pre = issue && (op == OP_PRE);

  // Auto-precharge: internal precharge waits for tRAS and write recovery,
  // reads also wait until the burst has left the pins.
  always_comb begin
    ap_base     = (op == OP_WR) ? WAP_LD : (CW'(cas_lat) + CW'(BURST - 1));
    ap_from_ras = ras_cnt + RP_LD;
    ap_from_wr  = wr_cnt + RP_LD;
    ap_ld       = ap_base;
    if (ap_from_ras > ap_ld) ap_ld = ap_from_ras;
    if (ap_from_wr  > ap_ld) ap_ld = ap_from_wr;
    rp_ld       = ld_pre ? RP_LD : ap_ld;
  end

  sbt_down_cnt #(.W(CW)) rcd_u (.clk(clk), .rst_n(rst_n), .load(ld_act),
                                .load_val(RCD_LD), .cnt(rcd_cnt));
  sbt_down_cnt #(.W(CW)) ras_u (.clk(clk), .rst_n(rst_n), .load(ld_act),
                                .load_val(RAS_LD), .cnt(ras_cnt));
  sbt_down_cnt #(.W(CW)) wr_u  (.clk(clk), .rst_n(rst_n), .load(ld_wr),
                                .load_val(WR_LD), .cnt(wr_cnt));
  sbt_down_cnt #(.W(CW)) rp_u  (.clk(clk), .rst_n(rst_n), .load(ld_pre || ld_ap),
                                .load_val(rp_ld), .cnt(rp_cnt));

  always_comb begin
    open_d = is_open;
    row_d  = open_row;
    age_d  = age_q;
    if (ld_act) begin
      open_d = 1'b1;
      row_d  = row;
      age_d  = AGE_W'(1);
    end else begin
      if (ld_pre || ld_ap) open_d = 1'b0;
      if (is_open && (age_q < AGE_LIM)) age_d = age_q + AGE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_open  <= 1'b0;
      open_row <= '0;
      age_q    <= '0;
    end else begin
      is_open  <= open_d;
      open_row <= row_d;
      age_q    <= age_d;
    end
  end

  assign act_ok    = !is_open && (rp_cnt == '0);
  assign col_ok    = is_open && (rcd_cnt == '0);
  assign pre_ok    = is_open && (ras_cnt == '0) && (wr_cnt == '0);
  assign close_due = is_open && (age_q >= AGE_LIM);
endmodule

// File: rtl/sbt_tracker.sv
`timescale 1ns/1ps
module sbt_tracker
  import sbt_pkg::*;
#(
  parameter int BANKS     = 4,
  parameter int ROW_W     = 12,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 1,
  parameter int BURST     = 4,
  parameter int T_RAS_MAX = 17142,
  localparam int BANK_W   = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             cas_lat,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_op,
  input  logic [BANK_W-1:0]      cmd_bank,
  input  logic [ROW_W-1:0]       cmd_row,
  input  logic                   cmd_ap,
  output logic [3:0]             legal_vec,
  output logic                   cmd_legal,
  output logic                   row_hit,
  output logic                   row_miss,
  output logic [BANKS-1:0]       bank_open,
  output logic [BANKS*ROW_W-1:0] open_rows,
  output logic [BANKS-1:0]       close_due
);
  localparam int MAXL  = T_RAS + T_RP + BURST + T_WR + 4;
  localparam int CW    = $clog2(MAXL + 1);
  localparam int AGE_W = $clog2(T_RAS_MAX + 1);
  localparam int RW    = $clog2(T_RRD + 1);

  sbt_op_e          op;
  logic [BANKS-1:0] act_ok_b, col_ok_b, pre_ok_b;
  logic [ROW_W-1:0] row_b [BANKS];
  logic [RW-1:0]    rrd_cnt;
  logic             issue, issue_act;

  assign op        = sbt_op_e'(cmd_op);
  assign issue     = cmd_valid && cmd_legal;
  assign issue_act = issue && (op == OP_ACT);

  sbt_down_cnt #(.W(RW)) rrd_u (.clk(clk), .rst_n(rst_n), .load(issue_act),
                                .load_val(RW'(T_RRD - 1)), .cnt(rrd_cnt));

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    sbt_bank #(
      .ROW_W(ROW_W), .CW(CW), .AGE_W(AGE_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
      .T_RP(T_RP), .T_WR(T_WR), .BURST(BURST), .T_RAS_MAX(T_RAS_MAX)
    ) bank_u (
      .clk(clk), .rst_n(rst_n),
      .issue(issue && (cmd_bank == BANK_W'(b))),
      .op(op), .ap(cmd_ap), .row(cmd_row), .cas_lat(cas_lat),
      .is_open(bank_open[b]), .open_row(row_b[b]),
      .act_ok(act_ok_b[b]), .col_ok(col_ok_b[b]), .pre_ok(pre_ok_b[b]),
      .close_due(close_due[b])
    );
    assign open_rows[b*ROW_W +: ROW_W] = row_b[b];
  end

  always_comb begin
    legal_vec[OP_ACT] = act_ok_b[cmd_bank] && (rrd_cnt == '0);
    legal_vec[OP_RD]  = col_ok_b[cmd_bank];
    legal_vec[OP_WR]  = col_ok_b[cmd_bank];
    legal_vec[OP_PRE] = pre_ok_b[cmd_bank];
  end

  assign cmd_legal = legal_vec[cmd_op];
  assign row_hit   = bank_open[cmd_bank] && (row_b[cmd_bank] == cmd_row);
  assign row_miss  = bank_open[cmd_bank] && (row_b[cmd_bank] != cmd_row);
endmodule

// File: rtl/sbt_tracker_chk.sv
`timescale 1ns/1ps
module sbt_tracker_chk #(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 12,
  parameter int T_RRD  = 2,
  parameter int BANK_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic [1:0]             cmd_op,
  input logic [BANK_W-1:0]      cmd_bank,
  input logic [3:0]             legal_vec,
  input logic                   cmd_legal,
  input logic [BANKS-1:0]       bank_open,
  input logic [BANKS*ROW_W-1:0] open_rows,
  input logic [BANKS-1:0]       close_due
);
  // R2
  act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    legal_vec[0] |-> !bank_open[cmd_bank]);

  // R2
  rrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((T_RRD > 1) && cmd_valid && cmd_legal && (cmd_op == 2'd0)) |=> !legal_vec[0]);

  // R3
  col_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_vec[1] || legal_vec[2]) |-> bank_open[cmd_bank]);

  // R11
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_legal && (cmd_op == 2'd0)) |=> bank_open[$past(cmd_bank)]);

  // R5
  pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_legal && (cmd_op == 2'd3)) |=> !bank_open[$past(cmd_bank)]);

  // R8
  held_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmd_valid && cmd_legal)) |=> ($stable(bank_open) && $stable(open_rows)));

  // R10
  due_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((close_due & ~bank_open) == '0));
endmodule

bind sbt_tracker sbt_tracker_chk #(
  .BANKS(BANKS), .ROW_W(ROW_W), .T_RRD(T_RRD), .BANK_W(BANK_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .legal_vec(legal_vec), .cmd_legal(cmd_legal),
  .bank_open(bank_open), .open_rows(open_rows), .close_due(close_due)
);

// File: tb/sbt_tracker_tb_top.sv
`timescale 1ns/1ps
module sbt_tracker_tb_top;
  localparam int BANKS = 4, ROW_W = 12;
  localparam int T_RCD = 3, T_RAS = 6, T_RP = 3, T_RRD = 2, T_WR = 1, BURST = 4;
  localparam int T_RAS_MAX = 24;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ap, cmd_legal, row_hit, row_miss;
  logic [1:0] cas_lat, cmd_op, cmd_bank;
  logic [ROW_W-1:0] cmd_row;
  logic [3:0] legal_vec;
  logic [BANKS-1:0] bank_open, close_due;
  logic [BANKS*ROW_W-1:0] open_rows;

  sbt_tracker #(.T_RAS_MAX(T_RAS_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_ap(cmd_ap),
    .legal_vec(legal_vec), .cmd_legal(cmd_legal), .row_hit(row_hit),
    .row_miss(row_miss), .bank_open(bank_open), .open_rows(open_rows),
    .close_due(close_due)
  );

  int checks = 0, errors = 0, n = 0;
  bit done = 0;
  bit m_open [BANKS];
  int m_row [BANKS], t_col [BANKS], t_ras [BANKS], t_wr [BANKS], t_act [BANKS], t_due [BANKS];
  int t_rrd;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic bit exp_legal(int op, int b);
    case (op)
      0:       return !m_open[b] && (n >= t_act[b]) && (n >= t_rrd);
      1, 2:    return m_open[b] && (n >= t_col[b]);
      default: return m_open[b] && (n >= t_ras[b]) && (n >= t_wr[b]);
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, n);
    end
  endtask

  task automatic model_issue(int op, int b, int row, bit ap);
    int ps;
    case (op)
      0: begin
        m_open[b] = 1; m_row[b] = row; t_col[b] = n + T_RCD;
        t_ras[b] = n + T_RAS; t_due[b] = n + T_RAS_MAX; t_rrd = n + T_RRD;
      end
      1: if (ap) begin
        m_open[b] = 0;
        ps = imax(n, imax(t_ras[b], t_wr[b]));
        t_act[b] = imax(n + int'(cas_lat) + BURST, ps + T_RP);
      end
      2: begin
        t_wr[b] = n + BURST - 1 + T_WR;
        if (ap) begin
          m_open[b] = 0;
          t_act[b] = imax(t_wr[b], t_ras[b]) + T_RP;
        end
      end
      default: begin
        m_open[b] = 0; t_act[b] = n + T_RP;
      end
    endcase
  endtask

  task automatic step(bit v, int op, int b, int row, bit ap, string tag, output bit issued);
    logic [3:0] ev;
    logic [BANKS-1:0] eo, ed;
    bit eh, em;
    @(negedge clk);
    cmd_valid = v; cmd_op = op[1:0]; cmd_bank = b[1:0];
    cmd_row = row[ROW_W-1:0]; cmd_ap = ap;
    #2;
    for (int k = 0; k < 4; k++) ev[k] = exp_legal(k, b);
    for (int k = 0; k < BANKS; k++) begin
      eo[k] = m_open[k];
      ed[k] = m_open[k] && (n >= t_due[k]);
    end
    eh = m_open[b] && (m_row[b] == row);
    em = m_open[b] && (m_row[b] != row);
    check(legal_vec == ev, tag, int'(legal_vec), int'(ev));
    check(cmd_legal == ev[op], "R12 cmd_legal", int'(cmd_legal), int'(ev[op]));
    check(bank_open == eo, "R8 R11 bank_open", int'(bank_open), int'(eo));
    check({row_hit, row_miss} == {eh, em}, "R9 hit/miss", int'({row_hit, row_miss}), int'({eh, em}));
    if (eo[b]) check(open_rows[b*ROW_W +: ROW_W] == row[ROW_W-1:0] || !eh, "R9 open_rows",
                     int'(open_rows[b*ROW_W +: ROW_W]), m_row[b]);
    check(close_due == ed, "R10 close_due", int'(close_due), int'(ed));
    issued = v && ev[op];
    if (issued) model_issue(op, b, row, ap);
    @(posedge clk);
    n++;
  endtask

  task automatic try_until(int op, int b, int row, bit ap, string tag, output int at);
    bit iss = 0;
    at = -1;
    for (int i = 0; i < 40 && !iss; i++) begin
      step(1, op, b, row, ap, tag, iss);
      if (iss) at = n - 1;
    end
  endtask

  task automatic idle(int cycles);
    bit iss;
    for (int i = 0; i < cycles; i++) step(0, 0, i % BANKS, 0, 0, "R8 idle", iss);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    int a0, a1, r0, w0, p0, a2, w1, a3, r1, a4, a5, r2, a6, a7;
    bit iss;
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < BANKS; k++) begin
      m_open[k] = 0; m_row[k] = 0; t_col[k] = -1000; t_ras[k] = -1000;
      t_wr[k] = -1000; t_act[k] = -1000; t_due[k] = -1000;
    end
    t_rrd = -1000;
    rst_n = 1'b0; cmd_valid = 0; cmd_op = 0; cmd_bank = 0; cmd_row = 0; cmd_ap = 0;
    cas_lat = 2'd3;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #2;
    // R1 reset state
    check(bank_open == '0, "R1 bank_open", int'(bank_open), 0);
    check(close_due == '0, "R1 close_due", int'(close_due), 0);
    check(legal_vec == 4'b0001, "R1 legal_vec", int'(legal_vec), 1);
    @(posedge clk);

    try_until(0, 0, 16, 0, "R2 act", a0);
    try_until(0, 1, 32, 0, "R2 act other bank", a1);
    check(a1 == a0 + T_RRD, "R2 act-to-act spacing", a1 - a0, T_RRD);
    try_until(1, 0, 16, 0, "R3 read", r0);
    check(r0 == a0 + T_RCD, "R3 act-to-read spacing", r0 - a0, T_RCD);
    try_until(2, 0, 16, 0, "R3 write", w0);
    try_until(3, 0, 16, 0, "R4 pre", p0);
    check(p0 == imax(a0 + T_RAS, w0 + BURST - 1 + T_WR), "R4 pre timing", p0,
          imax(a0 + T_RAS, w0 + BURST - 1 + T_WR));
    try_until(0, 0, 17, 0, "R5 act after pre", a2);
    check(a2 == p0 + T_RP, "R5 pre-to-act spacing", a2 - p0, T_RP);
    try_until(2, 0, 17, 1, "R6 write ap", w1);
    try_until(0, 0, 18, 0, "R6 act after write ap", a3);
    check(a3 == imax(w1 + BURST - 1 + T_WR, a2 + T_RAS) + T_RP, "R6 write ap reopen",
          a3, imax(w1 + BURST - 1 + T_WR, a2 + T_RAS) + T_RP);
    cas_lat = 2'd3;
    try_until(1, 1, 32, 1, "R7 read ap cl3", r1);
    try_until(0, 1, 33, 0, "R7 act after read ap", a4);
    check(a4 == r1 + 3 + BURST, "R7 read ap cl3 reopen", a4 - r1, 3 + BURST);
    cas_lat = 2'd2;
    try_until(0, 2, 40, 0, "R2 act bank2", a5);
    try_until(1, 2, 40, 1, "R7 read ap cl2", r2);
    try_until(0, 2, 41, 0, "R7 act after read ap cl2", a6);
    check(a6 == imax(r2 + 2 + BURST, imax(r2, a5 + T_RAS) + T_RP), "R7 read ap cl2 reopen",
          a6, imax(r2 + 2 + BURST, imax(r2, a5 + T_RAS) + T_RP));
    try_until(0, 3, 7, 0, "R11 act bank3", a7);
    idle(T_RAS_MAX + 2);
    #1;
    check(close_due[3] == 1'b1, "R10 close_due after limit", int'(close_due[3]), 1);
    check(bank_open == 4'b1111, "R11 all banks open", int'(bank_open), 15);

    for (int i = 0; i < 4000; i++) begin
      int op, b;
      bit v, ap;
      string tag;
      if (i % 800 == 0) cas_lat = (cas_lat == 2'd2) ? 2'd3 : 2'd2;
      v = ($urandom % 10) < 8;
      op = $urandom % 4;
      b = $urandom % BANKS;
      ap = ($urandom % 3) == 0;
      case (op)
        0: tag = "R2 rnd act";
        1: tag = ap ? "R7 rnd read" : "R3 rnd read";
        2: tag = ap ? "R6 rnd write" : "R3 rnd write";
        default: tag = "R4 rnd pre";
      endcase
      step(v, op, b, $urandom % 3, ap, tag, iss);
    end
    finish_run();
  end
endmodule